// File: doc/BRIEF.md
# Burst Preamble Inserter

This block builds the serial bit stream for one transmitted burst. It first sends a programmable preamble of up to 96 bits, then passes payload bits straight through from an upstream source. The preamble pattern is stored in twelve byte-wide configuration registers that are written through a simple byte write port. A separate length input sets how many of those bits go out.

A burst lasts as long as the transmit-enable input stays high. On the first enabled cycle the block takes a private copy of the twelve bytes and of the length. From the next cycle it emits the preamble one bit per cycle, most significant stored bit first. While it does so it keeps the payload source stalled. It then raises payload ready and forwards payload bits together with their valid flag. When transmit-enable falls, output valid and ready drop in that same cycle and the block goes back to idle.

Top module: `burst_preamble_inserter`

## Requirements
- R1: After reset, out_valid and pay_ready are 0 and all twelve pattern bytes hold 0x00. A 96-bit burst sent before any write therefore emits only zeros.
- R2: When cfg_we is high in a cycle, cfg_wdata is stored in the byte at index cfg_addr for indices 0 to 11. Writes to indices 12 to 15 change no stored byte.
- R3: A burst starts in the first cycle where tx_en is high while the block is idle (the start cycle). In that cycle out_valid is 0. Preamble bit i (counting from 0) appears on out_bit with out_valid high in the cycle start+1+i.
- R4: Bit order: the flattened pattern places byte k bit b at position 8k+b. Preamble bit i is position 95-i, so the first bit sent is bit 7 of byte 11 and the order then runs downward.
- R5: When the length latched at start is 0, no preamble is sent: pay_ready is high from cycle start+1.
- R6: A length value above 96 is treated as 96.
- R7: pay_ready is 0 during the preamble and goes high in the cycle after the last preamble bit. While pay_ready is high, out_bit equals pay_bit and out_valid equals pay_valid, with no delay.
- R8: In any cycle where tx_en is low, out_valid and pay_ready are 0. This holds even when tx_en falls partway through the preamble. The next high tx_en starts a new burst with a fresh copy of the pattern.
- R9: Pattern and length are sampled only in the start cycle. A byte write issued in the start cycle itself, or later in the burst, affects only later bursts. A length change during the burst has no effect on the running burst.
- R10: A payload cycle with pay_valid low gives out_valid low and does not end the payload phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | High for the duration of a burst |
| pre_len | input | 7 | Requested preamble length in bits |
| cfg_we | input | 1 | Pattern byte write strobe |
| cfg_addr | input | 4 | Pattern byte index |
| cfg_wdata | input | 8 | Pattern byte value |
| pay_bit | input | 1 | Payload data bit |
| pay_valid | input | 1 | Payload bit valid |
| pay_ready | output | 1 | Block accepts payload this cycle |
| out_bit | output | 1 | Serial output bit |
| out_valid | output | 1 | Serial output bit valid |

## Verification
The write port and the burst-start snapshot can act in the same cycle. The bench provokes this by overwriting byte 11, which holds the first bits to go out, in exactly the start cycle. It expects the burst to carry the old byte value and the following burst to carry the new one. A second collision is a transmit-enable drop in the middle of the preamble, at the same edge where the bit counter would advance. The bench judges it by output valid and ready being low in that cycle and by a clean preamble on the next burst. All of this runs over a sweep of every length from 0 to 100, with a different pattern for each length.

// File: rtl/pbi_pkg.sv
package pbi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_PAY  = 2'd2
    } burst_state_e;

    typedef struct packed {
        logic bit_val;
        logic valid;
    } ser_beat_t;

    function automatic int unsigned clamp_len(input int unsigned req, input int unsigned maxv);
        return (req > maxv) ? maxv : req;
    endfunction

endpackage

// File: rtl/pbi_bank.sv
module pbi_bank #(
    parameter int NUM_BYTES = 12,
    parameter int ADDR_W    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    output logic [NUM_BYTES*8-1:0] image
);

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(k))) begin
                byte_q <= wr_data;
            end
        end
        assign image[k*8 +: 8] = byte_q;
    end

    // An index beyond the bank must leave every byte untouched.
    assert_oob_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_addr) >= NUM_BYTES)) |=> $stable(image));

endmodule

// File: rtl/pbi_shifter.sv
module pbi_shifter #(
    parameter int PRE_BITS = 96,
    parameter int LEN_W    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                advance,
    input  logic [PRE_BITS-1:0] image,
    input  logic [LEN_W-1:0]    len_req,
    output logic                head_bit,
    output logic                last_bit,
    output logic                zero_len
);

    logic [PRE_BITS-1:0] sh_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    cnt_q;
    logic [LEN_W-1:0]    len_eff;

    assign len_eff = LEN_W'(pbi_pkg::clamp_len(int'(len_req), PRE_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            len_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= image;
            len_q <= len_eff;
            cnt_q <= '0;
        end else if (advance) begin
            sh_q  <= {sh_q[PRE_BITS-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign head_bit = sh_q[PRE_BITS-1];
    assign last_bit = (cnt_q == (len_q - 1'b1));
    assign zero_len = (len_eff == '0);

    // The controller must never step past the latched length.
    assert_cnt_within_len_R6: assert property (@(posedge clk) disable iff (rst)
        advance |-> (cnt_q < len_q));

    // A latched length never exceeds the pattern size.
    assert_len_capped_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> (int'(len_q) <= PRE_BITS));

endmodule

// File: rtl/pbi_ctrl.sv
module pbi_ctrl
    import pbi_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_en,
    input  logic         zero_len,
    input  logic         last_bit,
    output burst_state_e state,
    output logic         load,
    output logic         advance
);

    burst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en) begin
                    load    = 1'b1;
                    state_d = zero_len ? ST_PAY : ST_PRE;
                end
            end
            ST_PRE: begin
                if (!tx_en) begin
                    state_d = ST_IDLE;
                end else if (last_bit) begin
                    state_d = ST_PAY;
                end
            end
            ST_PAY: begin
                if (!tx_en) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign advance = (state_q == ST_PRE) && tx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // Dropping the enable always leaves the burst.
    assert_drop_returns_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (state_q == ST_IDLE));

endmodule

// File: rtl/burst_preamble_inserter.sv
module burst_preamble_inserter
    import pbi_pkg::*;
#(
    parameter  int NUM_BYTES = 12,
    localparam int PRE_BITS  = NUM_BYTES * 8,
    localparam int LEN_W     = $clog2(PRE_BITS + 1),
    localparam int ADDR_W    = $clog2(NUM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [LEN_W-1:0]  pre_len,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              pay_bit,
    input  logic              pay_valid,
    output logic              pay_ready,
    output logic              out_bit,
    output logic              out_valid
);

    logic [PRE_BITS-1:0] image;
    logic                head_bit, last_bit, zero_len;
    logic                load, advance;
    burst_state_e        cur_state;
    ser_beat_t           beat;

    pbi_bank #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .image   (image)
    );

    pbi_shifter #(.PRE_BITS(PRE_BITS), .LEN_W(LEN_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .advance  (advance),
        .image    (image),
        .len_req  (pre_len),
        .head_bit (head_bit),
        .last_bit (last_bit),
        .zero_len (zero_len)
    );

    pbi_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .zero_len (zero_len),
        .last_bit (last_bit),
        .state    (cur_state),
        .load     (load),
        .advance  (advance)
    );

    always_comb begin
        beat = '0;
        if (tx_en) begin
            unique case (cur_state)
                ST_PRE: begin
                    beat.bit_val = head_bit;
                    beat.valid   = 1'b1;
                end
                ST_PAY: begin
                    beat.bit_val = pay_bit;
                    beat.valid   = pay_valid;
                end
                default: beat = '0;
            endcase
        end
    end

    assign out_bit   = beat.bit_val;
    assign out_valid = beat.valid;
    assign pay_ready = tx_en && (cur_state == ST_PAY);

    // Payload is only released once the counter has reached the final preamble bit.
    assert_ready_after_last_bit_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(pay_ready) && $past(cur_state == ST_PRE)) |-> $past(last_bit));

    // Accepted payload bits pass straight to the output.
    assert_payload_passthrough_R7: assert property (@(posedge clk) disable iff (rst)
        (pay_ready && pay_valid) |-> (out_valid && (out_bit == pay_bit)));

    // No output activity while idle.
    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_IDLE) |-> (!out_valid && !pay_ready));

endmodule

// File: tb/sim_burst_preamble_inserter.sv
module sim_burst_preamble_inserter;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 12;
    localparam int PB = NB * 8;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx_en = 1'b0;
    logic [LW-1:0] pre_len = '0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          pay_bit = 1'b0;
    logic          pay_valid = 1'b0;
    wire           pay_ready, out_bit, out_valid;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NB];
    logic [7:0] snap  [NB];

    burst_preamble_inserter u0 (
        .clk (clk), .rst (rst), .tx_en (tx_en), .pre_len (pre_len),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .pay_bit (pay_bit), .pay_valid (pay_valid), .pay_ready (pay_ready),
        .out_bit (out_bit), .out_valid (out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(a);
        cfg_wdata = 8'(d);
        if (a < NB) model[a] = 8'(d);
    endtask

    task automatic run_burst(input int len, input int npay, input int abort_at, input bit collide);
        int  leff;
        int  pos;
        bit  aborted;
        leff    = (len > PB) ? PB : len;
        aborted = 1'b0;
        @(negedge clk);
        cfg_we    = 1'b0;
        tx_en     = 1'b1;
        pre_len   = LW'(len);
        pay_valid = 1'b1;
        pay_bit   = 1'b1;
        for (int k = 0; k < NB; k++) snap[k] = model[k];
        if (collide) begin
            // R9: write the first-sent byte in the start cycle itself
            cfg_we        = 1'b1;
            cfg_addr      = 4'(NB-1);
            cfg_wdata     = ~model[NB-1];
            model[NB-1]   = ~model[NB-1];
        end
        #1;
        chk("R3 start cycle out_valid", out_valid, 0);
        chk("R3 start cycle pay_ready", pay_ready, 0);
        for (int i = 0; i < leff; i++) begin
            @(negedge clk);
            cfg_we    = (i == 0);
            cfg_addr  = 4'(NB-1);
            cfg_wdata = 8'(len + 1);
            if (i == 0) model[NB-1] = 8'(len + 1);
            pre_len = LW'(len ^ 'h2a);   // R9: length change mid-burst
            if (i == abort_at) begin
                tx_en = 1'b0;
                #1;
                chk("R8 abort out_valid", out_valid, 0);
                chk("R8 abort pay_ready", pay_ready, 0);
                aborted = 1'b1;
                break;
            end
            #1;
            pos = PB - 1 - i;
            chk("R4 R9 preamble bit", out_bit, snap[pos/8][pos%8]);
            chk("R3 preamble out_valid", out_valid, 1);
            chk("R7 preamble pay_ready", pay_ready, 0);
        end
        if (!aborted) begin
            for (int j = 0; j < npay; j++) begin
                @(negedge clk);
                cfg_we    = 1'b0;
                pay_valid = (j != 2);
                pay_bit   = ((j + len) % 2) == 1;
                #1;
                chk((leff == 0) ? "R5 payload pay_ready" : "R6 R7 payload pay_ready", pay_ready, 1);
                chk("R10 payload out_valid", out_valid, int'(pay_valid));
                if (pay_valid) chk("R7 payload out_bit", out_bit, int'(pay_bit));
            end
            @(negedge clk);
            tx_en     = 1'b0;
            pay_valid = 1'b1;
            #1;
            chk("R8 end out_valid", out_valid, 0);
            chk("R8 end pay_ready", pay_ready, 0);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        tx_en  = 1'b0;
        #1;
        chk("R8 idle out_valid", out_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NB; k++) model[k] = 8'h00;
        tx_en = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset out_valid", out_valid, 0);
        chk("R1 reset pay_ready", pay_ready, 0);
        @(negedge clk);
        rst   = 1'b0;
        tx_en = 1'b0;

        // R1: cleared pattern bytes give an all-zero preamble
        run_burst(96, 3, -1, 1'b0);

        // R2: writes outside the bank leave the pattern unchanged
        for (int a = NB; a < 16; a++) wr(a, 8'hff);
        run_burst(96, 3, -1, 1'b0);

        // Sweep every length, fresh pattern each time
        for (int len = 0; len <= 100; len++) begin
            for (int k = 0; k < NB; k++) wr(k, (k * 37 + len * 11 + 5) & 255);
            run_burst(len, 5, ((len % 9) == 5) ? len / 2 : -1, (len % 4) == 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule